// File: doc/BRIEF.md
# Two's Complement Non-Restoring Fraction Divider

This block divides one signed two's complement fraction by another, one quotient bit per clock, using the alternating add/subtract method. Both operands are `W` bits wide with the binary point just right of the sign bit. The dividend's magnitude must be smaller than the divisor's, which keeps the quotient a proper fraction. The quotient has `W` bits: a sign bit and `W-1` fraction bits. The remainder is the uncorrected final partial remainder, held with two sign bits.

A controller steps through four states. `ST_IDLE` waits for `start`. `ST_FIRST` makes the opening add or subtract. `ST_ITER` runs `W-1` times, once per quotient bit. `ST_FINAL` appends the last quotient bit as a constant 1. The transitions are:

- `ST_IDLE` → `ST_FIRST` on `start` with a nonzero divisor.
- `ST_IDLE` → `ST_IDLE` on `start` with a zero divisor. This finishes at once with the zero-divisor flag set.
- `ST_FIRST` → `ST_ITER` unconditionally.
- `ST_ITER` → `ST_ITER` until the step counter reaches its last value, then `ST_ITER` → `ST_FINAL`.
- `ST_FINAL` → `ST_IDLE`, raising `done`.

The datapath holds three registers. The partial remainder is `W+1` bits. The divisor is latched at start. The quotient is shifted left one bit per step.

Top module: `tc_nonrestore_div`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all 0.
- R2: When `start` is seen in idle with a nonzero divisor, `busy` is high from the next cycle for exactly `W+1` cycles. `done` is high in the first cycle after that, with `busy` low.
- R3: Each quotient bit is 1 when the partial remainder and the divisor have the same sign, otherwise 0. The result satisfies dividend·2^(W-1) = quotient·divisor + remainder exactly, as signed integers.
- R4: For a nonzero divisor, bit 0 of `quotient` is always 1.
- R5: For every operand pair with |dividend| < |divisor|, `quotient` differs from the truncated value of dividend·2^(W-1)/divisor by at most 1.
- R6: The opening step subtracts the divisor when the dividend and divisor have the same sign and adds it otherwise. The `W+1`-bit remainder never overflows and ends with |remainder| ≤ |divisor|.
- R7: `start` with a zero divisor sets `div_zero`, sets `quotient` to 0 and `remainder` to the sign-extended dividend, raises `done` in the next cycle, and never raises `busy`.
- R8: A `start` while `busy` is high is ignored. The running division completes on its original operands in its original time.
- R9: `quotient`, `remainder` and `div_zero` hold their values until the next accepted `start`. A division with a nonzero divisor clears `div_zero`.
- R10: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; sampled only while idle |
| dividend | input | W | Signed fraction dividend |
| divisor | input | W | Signed fraction divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results become valid |
| quotient | output | W | Signed fraction quotient, last bit forced to 1 |
| remainder | output | W+1 | Final partial remainder, two sign bits |
| div_zero | output | 1 | The last accepted request had a zero divisor |

## Verification
`start` is sampled on a rising edge, and `busy` is due one cycle after it. For a nonzero divisor, `done` and the results are due `W+2` cycles after that edge. For a zero divisor they are due one cycle after it. Inputs change on falling edges and every output is sampled on a falling edge. The bench counts falling edges from the start request and compares that count against these figures for every division, so an early or late result fails. Results are checked only at the `done` cycle and at later idle cycles, where they must be held.

// File: rtl/tcdiv_pkg.sv
package tcdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_ITER,
        ST_FINAL
    } div_state_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_LOAD,
        OP_ZERO,
        OP_FIRST,
        OP_ITER,
        OP_FINAL
    } div_op_e;

endpackage

// File: rtl/tcdiv_ctrl.sv
module tcdiv_ctrl
    import tcdiv_pkg::*;
#(
    parameter int N_STEPS = 7
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    divisor_zero,
    output div_op_e op,
    output logic    busy,
    output logic    done
);

    localparam int CW = $clog2(N_STEPS + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(N_STEPS - 1);
    localparam logic [CW-1:0] STEP_LIMIT = CW'(N_STEPS);

    div_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start && !divisor_zero) state_d = ST_FIRST;
            ST_FIRST: state_d = ST_ITER;
            ST_ITER:  if (cnt_q == LAST_STEP) state_d = ST_FINAL;
            ST_FINAL: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode: datapath command and busy
    always_comb begin
        op = OP_HOLD;
        unique case (state_q)
            ST_IDLE:  if (start) op = divisor_zero ? OP_ZERO : OP_LOAD;
            ST_FIRST: op = OP_FIRST;
            ST_ITER:  op = OP_ITER;
            ST_FINAL: op = OP_FINAL;
            default:  op = OP_HOLD;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    // Step counter and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= (state_q == ST_FINAL) ||
                    ((state_q == ST_IDLE) && start && divisor_zero);
            if (state_q == ST_IDLE)      cnt_q <= '0;
            else if (state_q == ST_ITER) cnt_q <= cnt_q + CW'(1);
        end
    end

    p_iter_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER) |-> (cnt_q < STEP_LIMIT));

    p_final_gives_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINAL) |=> (done && !busy));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

endmodule

// File: rtl/tcdiv_addsub.sv
module tcdiv_addsub #(
    parameter int W = 8
) (
    input  logic [W:0]   acc,
    input  logic         dbl,
    input  logic [W-1:0] dvs,
    output logic [W+1:0] sum,
    output logic         same_sign
);

    logic [W+1:0] base;
    logic [W+1:0] dext;

    always_comb begin
        base      = dbl ? {acc, 1'b0} : {acc[W], acc};
        dext      = {{2{dvs[W-1]}}, dvs};
        same_sign = (acc[W] == dvs[W-1]);
        sum       = same_sign ? (base - dext) : (base + dext);
    end

endmodule

// File: rtl/tcdiv_datapath.sv
module tcdiv_datapath
    import tcdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  div_op_e      op,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    output logic [W-1:0] quot,
    output logic [W:0]   rem,
    output logic         dz
);

    logic [W:0]   a_q;
    logic [W-1:0] b_q;
    logic [W-1:0] c_q;
    logic         dz_q;
    logic [W+1:0] sum_w;
    logic         same_w;

    tcdiv_addsub #(.W(W)) u_addsub (
        .acc       (a_q),
        .dbl       (op == OP_ITER),
        .dvs       (b_q),
        .sum       (sum_w),
        .same_sign (same_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            c_q  <= '0;
            dz_q <= 1'b0;
        end else begin
            case (op)
                OP_LOAD: begin
                    a_q  <= {x_in[W-1], x_in};
                    b_q  <= y_in;
                    c_q  <= '0;
                    dz_q <= 1'b0;
                end
                OP_ZERO: begin
                    a_q  <= {x_in[W-1], x_in};
                    b_q  <= y_in;
                    c_q  <= '0;
                    dz_q <= 1'b1;
                end
                OP_FIRST: a_q <= sum_w[W:0];
                OP_ITER: begin
                    a_q <= sum_w[W:0];
                    c_q <= {c_q[W-2:0], same_w};
                end
                OP_FINAL: c_q <= {c_q[W-2:0], 1'b1};
                default: ;
            endcase
        end
    end

    assign quot = c_q;
    assign rem  = a_q;
    assign dz   = dz_q;

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_FIRST) || (op == OP_ITER)) |-> (sum_w[W+1] == sum_w[W]));

    p_divisor_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_FIRST) || (op == OP_ITER) || (op == OP_FINAL)) |=> $stable(b_q));

    p_lsb_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FINAL) |=> c_q[0]);

endmodule

// File: rtl/tc_nonrestore_div.sv
module tc_nonrestore_div
    import tcdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W:0]   remainder,
    output logic         div_zero
);

    localparam int N_STEPS = W - 1;

    div_op_e op_w;
    logic    y_zero;

    assign y_zero = (divisor == '0);

    tcdiv_ctrl #(.N_STEPS(N_STEPS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .divisor_zero (y_zero),
        .op           (op_w),
        .busy         (busy),
        .done         (done)
    );

    tcdiv_datapath #(.W(W)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op_w),
        .x_in  (dividend),
        .y_in  (divisor),
        .quot  (quotient),
        .rem   (remainder),
        .dz    (div_zero)
    );

    p_zero_quotient_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == '0));

    p_results_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

    p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/sim_tc_nonrestore_div.sv
module sim_tc_nonrestore_div;

    localparam int CLK_PERIOD = 10;
    localparam int W = 6;
    localparam int N = W - 1;
    localparam int SCALE = 1 << N;
    localparam int LAT = W + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;
    logic [W:0]   remainder;
    logic         div_zero;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tc_nonrestore_div #(.W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder),
        .div_zero  (div_zero)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issues one request and waits for done; lat counts falling edges after the start edge.
    task automatic run_div(input int xi, input int yi, output int q, output int r, output int lat);
        @(negedge clk);
        dividend = xi[W-1:0];
        divisor  = yi[W-1:0];
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        q = $signed(quotient);
        r = $signed(remainder);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy at reset", busy, 0);
        chk(done == 1'b0, "R1 done at reset", done, 0);
        chk(div_zero == 1'b0, "R1 div_zero at reset", div_zero, 0);
        chk(quotient == '0, "R1 quotient at reset", quotient, 0);
        chk(remainder == '0, "R1 remainder at reset", remainder, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_directed;
        int q, r, lat;
        run_div(16, 24, q, r, lat);
        chk(q == 21, "R3 quotient 0.5/0.75", q, 21);
        chk(r == 8, "R3 remainder 0.5/0.75", r, 8);
        chk(lat == LAT, "R2 latency 0.5/0.75", lat, LAT);
        run_div(-16, 24, q, r, lat);
        chk(q == -21, "R6 quotient -0.5/0.75", q, -21);
        chk(r == -8, "R6 remainder -0.5/0.75", r, -8);
        run_div(0, 24, q, r, lat);
        chk(q == 1, "R4 quotient 0/0.75", q, 1);
        chk(r == -24, "R3 remainder 0/0.75", r, -24);
    endtask

    task automatic t_timing;
        @(negedge clk);
        dividend = 6'd10;
        divisor  = 6'd20;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= W + 1; k++) begin
            chk(busy == 1'b1, "R2 busy during run", busy, 1);
            chk(done == 1'b0, "R10 done early", done, 0);
            @(negedge clk);
        end
        chk(done == 1'b1, "R2 done due", done, 1);
        chk(busy == 1'b0, "R2 busy low with done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", done, 0);
    endtask

    task automatic t_zero;
        int q, r, lat;
        run_div(9, 0, q, r, lat);
        chk(lat == 1, "R7 zero divisor latency", lat, 1);
        chk(busy == 1'b0, "R7 busy stays low", busy, 0);
        chk(div_zero == 1'b1, "R7 div_zero set", div_zero, 1);
        chk(q == 0, "R7 quotient zero", q, 0);
        chk(r == 9, "R7 remainder is dividend", r, 9);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single after zero", done, 0);
        run_div(16, 24, q, r, lat);
        chk(div_zero == 1'b0, "R9 div_zero cleared", div_zero, 0);
        chk(q == 21, "R9 quotient after clear", q, 21);
    endtask

    task automatic t_busy_start;
        int lat;
        @(negedge clk);
        dividend = 6'd16;
        divisor  = 6'd24;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        @(negedge clk);
        lat++;
        dividend = 6'(-5);
        divisor  = 6'd7;
        start    = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == LAT, "R8 latency unchanged", lat, LAT);
        chk($signed(quotient) == 21, "R8 quotient from first operands", $signed(quotient), 21);
        chk($signed(remainder) == 8, "R8 remainder from first operands", $signed(remainder), 8);
        @(negedge clk);
        chk(busy == 1'b0, "R8 no second run", busy, 0);
    endtask

    task automatic t_hold;
        int q, r, lat;
        run_div(-7, 13, q, r, lat);
        dividend = 6'd3;
        divisor  = 6'd0;
        repeat (5) @(negedge clk);
        chk($signed(quotient) == q, "R9 quotient held", $signed(quotient), q);
        chk($signed(remainder) == r, "R9 remainder held", $signed(remainder), r);
        chk(div_zero == 1'b0, "R9 div_zero held", div_zero, 0);
    endtask

    task automatic t_sweep;
        int q, r, lat, tq, ay, ax, diff;
        for (int y = -SCALE; y < SCALE; y++) begin
            for (int x = -SCALE; x < SCALE; x++) begin
                ax = (x < 0) ? -x : x;
                ay = (y < 0) ? -y : y;
                if (ax < ay) begin
                    run_div(x, y, q, r, lat);
                    tq = (x * SCALE) / y;
                    diff = q - tq;
                    chk(x * SCALE == q * y + r, "R3 identity", q * y + r, x * SCALE);
                    chk(diff <= 1 && diff >= -1, "R5 within one lsb", q, tq);
                    chk(q[0] == 1'b1, "R4 last bit one", q, q | 1);
                    chk(r <= ay && r >= -ay, "R6 remainder bound", r, ay);
                    chk(lat == LAT, "R2 latency sweep", lat, LAT);
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_directed();
        t_timing();
        t_zero();
        t_busy_start();
        t_hold();
        t_sweep();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule